// File: doc/BRIEF.md
# Rename stall controller

This block is the flow-control brain of the rename stage in an out-of-order core, for a single thread. Each cycle it sees a group of decoded instructions, the stall flags from the execute and commit stages, free-slot counts for the reorder buffer, the issue queue and the load/store queue, a squash request, a "reorder buffer still squashing" flag and a "reorder buffer empty" flag. It decides how many instructions move on to dispatch and holds the rest in an internal skid buffer. It sends one-cycle block and unblock strobes back to decode, and it enforces serializing instructions. Register lookup and allocation are not part of the block. The register file's capacity arrives as one "registers available" input.

Instructions are carried as tags with three marks: killed (squashed upstream), serialize-before and serialize-after. Renamed tags leave on registered output lanes one cycle after the edge at which they were taken. The skid buffer holds `2*DLY*DEC_W + WIDTH` entries, where `DLY` is the decode feedback delay in cycles.

Top module: `rename_stall_ctrl`

## Requirements
- R1: After reset, `state` is 0 and no lane or strobe is active. State codes are Idle 0, Running 1, Blocked 2, Unblocking 3, Squashing 4 and SerializeStall 5. Idle moves to Running on the first cycle that offers instructions with no stall.
- R2: With no stall, up to `WIDTH` instructions are passed per cycle in arrival order. They appear one cycle later on `out_valid` and `out_tag`, the oldest on lane 0 (`out_tag[ID_W-1:0]`). Decode offers valid lanes packed from lane 0.
- R3: The usable room is min(`rob_free`, `iq_free`, `lsq_free`) minus the instructions in flight. Instructions in flight are those renamed but not yet reported through `disp_cnt`. The count passed per cycle is also capped by this room. Any instruction left over moves the stage to Blocked.
- R4: If `exe_stall`, `cmt_stall` or a low `regs_ok` is set, or the usable room is zero, nothing is passed and all pending instructions go into the skid buffer. `to_dec_block` pulses only when entering from a state other than Blocked, Unblocking or SerializeStall.
- R5: When the stall clears, the stage leaves Blocked and passes skid-buffer entries before new decode input. Once the skid buffer is empty, the stage pulses `to_dec_unblock` and returns to Running. If entries are still left, it goes back to Blocked without a strobe.
- R6: `squash` has top priority. It discards the skid buffer and the decode input and enters Squashing. It pulses `to_dec_unblock` if the stage was Blocked, Unblocking or SerializeStall. The next cycle with no squash and no stall returns to Running.
- R7: `rob_squashing`, below `squash` and above the stall conditions, holds Squashing and discards all pending instructions.
- R8: A serialize-before instruction stops renaming in front of itself and enters SerializeStall, pulsing `to_dec_block`. The stage stays in SerializeStall, never moving to Blocked, while the reorder buffer is not empty, instructions are in flight, or any other stall is present. After that, the held instruction is passed first and the stage unblocks.
- R9: A serialize-after instruction makes the next live instruction serialize-before, even when that instruction arrives in a later cycle. This pending mark is dropped if, at the start of a cycle, the reorder buffer is empty and nothing is in flight.
- R10: Killed instructions are consumed silently: they never appear on the output and count toward neither the width nor the room limit.
- R11: The skid buffer never holds more than `2*DLY*DEC_W + WIDTH` entries. A full buffer drains completely and in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dec_valid | input | DEC_W | Decode lanes carrying an instruction |
| dec_kill | input | DEC_W | Lane instruction already squashed |
| dec_ser_pre | input | DEC_W | Lane instruction is serialize-before |
| dec_ser_post | input | DEC_W | Lane instruction is serialize-after |
| dec_tag | input | DEC_W*ID_W | Lane instruction tags, lane 0 lowest |
| exe_stall | input | 1 | Stall request from the execute stage |
| cmt_stall | input | 1 | Stall request from the commit stage |
| regs_ok | input | 1 | Free rename registers are available |
| squash | input | 1 | Squash request |
| rob_squashing | input | 1 | Reorder buffer still squashing |
| rob_empty | input | 1 | Reorder buffer is empty |
| rob_free | input | CNT_W | Reorder buffer free slots last reported |
| iq_free | input | CNT_W | Issue queue free slots last reported |
| lsq_free | input | CNT_W | Load/store queue free slots last reported |
| disp_cnt | input | CNT_W | Instructions dispatched this cycle |
| out_valid | output | WIDTH | Renamed output lanes valid |
| out_tag | output | WIDTH*ID_W | Renamed tags, lane 0 oldest |
| to_dec_block | output | 1 | One-cycle block strobe to decode |
| to_dec_unblock | output | 1 | One-cycle unblock strobe to decode |
| state | output | 3 | Current control state code |

## Verification
Two cases pile several events into one cycle. In the first, a squash arrives in the same cycle as an active execute stall and fresh decode input while the stage is Blocked. The bench expects Squashing with an unblock pulse, no output, and an empty skid buffer afterwards: the cycle after the squash passes nothing. In the second, a serialize-after and its successor arrive together. The first is renamed in that cycle and the second is turned into a serialize-before stall. The bench expects exactly one lane, a block pulse and state 5, and on release only the held tag.

// File: rtl/rename_stall_ctrl.sv
module rename_stall_ctrl #(
  parameter int WIDTH = 2,
  parameter int DEC_W = 2,
  parameter int DLY   = 1,
  parameter int ID_W  = 8,
  parameter int CNT_W = 6
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [DEC_W-1:0]      dec_valid,
  input  logic [DEC_W-1:0]      dec_kill,
  input  logic [DEC_W-1:0]      dec_ser_pre,
  input  logic [DEC_W-1:0]      dec_ser_post,
  input  logic [DEC_W*ID_W-1:0] dec_tag,
  input  logic                  exe_stall,
  input  logic                  cmt_stall,
  input  logic                  regs_ok,
  input  logic                  squash,
  input  logic                  rob_squashing,
  input  logic                  rob_empty,
  input  logic [CNT_W-1:0]      rob_free,
  input  logic [CNT_W-1:0]      iq_free,
  input  logic [CNT_W-1:0]      lsq_free,
  input  logic [CNT_W-1:0]      disp_cnt,
  output logic [WIDTH-1:0]      out_valid,
  output logic [WIDTH*ID_W-1:0] out_tag,
  output logic                  to_dec_block,
  output logic                  to_dec_unblock,
  output logic [2:0]            state
);
  localparam int SKID = 2 * DLY * DEC_W + WIDTH;
  localparam int WIN  = SKID + DEC_W;
  localparam int CW   = $clog2(WIN + 1);
  localparam int E_W  = ID_W + 4;
  localparam int F_KILL = ID_W, F_PRE = ID_W + 1, F_POST = ID_W + 2, F_DONE = ID_W + 3;
  localparam logic [2:0] S_IDLE = 3'd0, S_RUN = 3'd1, S_BLK = 3'd2,
                         S_UNB = 3'd3, S_SQ = 3'd4, S_SER = 3'd5;

  logic [2:0]       st, nst, mid;
  logic [E_W-1:0]   skid [SKID];
  logic [E_W-1:0]   nskid [SKID];
  logic [E_W-1:0]   win [WIN];
  logic [CW-1:0]    sc, nsc, wn, cut;
  logic [CNT_W-1:0] infl, mn, avail, lim, nren;
  logic             pend, npend, stall, carry, stop, ser, sbx, nblk, nunb;
  logic [WIDTH-1:0]      nv;
  logic [WIDTH*ID_W-1:0] nt;

  assign mn    = (rob_free < iq_free) ? ((rob_free < lsq_free) ? rob_free : lsq_free)
                                      : ((iq_free < lsq_free) ? iq_free : lsq_free);
  assign avail = (mn > infl) ? mn - infl : '0;
  assign lim   = (avail < CNT_W'(WIDTH)) ? avail : CNT_W'(WIDTH);
  assign stall = exe_stall | cmt_stall | ~regs_ok | (avail == '0) |
                 (st == S_SER && (!rob_empty || infl != '0));
  assign state = st;

  always_comb begin
    for (int i = 0; i < WIN; i++) win[i] = '0;
    for (int i = 0; i < SKID; i++) if (CW'(i) < sc) win[i] = skid[i];
    for (int j = 0; j < DEC_W; j++)
      if (dec_valid[j])
        win[int'(sc) + j] = {1'b0, dec_ser_post[j], dec_ser_pre[j], dec_kill[j],
                             dec_tag[j*ID_W +: ID_W]};
    wn = sc + CW'($countones(dec_valid));

    nst = st; mid = st; nsc = sc; nskid = skid; npend = pend;
    nv = '0; nt = '0; nblk = 1'b0; nunb = 1'b0;
    nren = '0; cut = wn; stop = 1'b0; ser = 1'b0; carry = 1'b0; sbx = 1'b0;

    if (squash) begin
      nst = S_SQ; nsc = '0; npend = 1'b0;
      nunb = (st == S_BLK || st == S_UNB || st == S_SER);
    end else if (rob_squashing) begin
      nst = S_SQ; nsc = '0; npend = 1'b0;
    end else if (stall) begin
      for (int k = 0; k < SKID; k++) nskid[k] = win[k];
      nsc  = wn;
      nblk = !(st == S_BLK || st == S_UNB || st == S_SER);
      if (st != S_SER) nst = S_BLK;
    end else begin
      mid   = (st == S_BLK || st == S_SER) ? S_UNB : (st == S_SQ) ? S_RUN : st;
      carry = pend && !(rob_empty && infl == '0);
      for (int i = 0; i < WIN; i++) begin
        if (CW'(i) < wn && !stop && !win[i][F_KILL]) begin
          sbx = win[i][F_PRE] | carry;
          carry = 1'b0;
          if (nren == lim) begin
            stop = 1'b1; cut = CW'(i); win[i][F_PRE] = sbx;
          end else if (sbx && !win[i][F_DONE]) begin
            stop = 1'b1; ser = 1'b1; cut = CW'(i);
            win[i][F_PRE] = 1'b1; win[i][F_DONE] = 1'b1;
          end else begin
            nv[nren] = 1'b1;
            nt[nren*ID_W +: ID_W] = win[i][ID_W-1:0];
            nren  = nren + 1'b1;
            carry = win[i][F_POST];
          end
        end
      end
      npend = carry;
      nsc   = wn - cut;
      for (int k = 0; k < SKID; k++)
        nskid[k] = (int'(cut) + k < WIN) ? win[int'(cut) + k] : '0;
      if (ser) begin
        nst = S_SER; nblk = (mid != S_UNB);
      end else if (nsc != '0) begin
        nst = S_BLK; nblk = (mid != S_UNB);
      end else if (mid == S_UNB) begin
        nst = S_RUN; nunb = 1'b1;
      end else if (mid == S_IDLE && wn != '0) begin
        nst = S_RUN;
      end else begin
        nst = mid;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; sc <= '0; infl <= '0; pend <= 1'b0;
      for (int k = 0; k < SKID; k++) skid[k] <= '0;
      out_valid <= '0; out_tag <= '0; to_dec_block <= 1'b0; to_dec_unblock <= 1'b0;
    end else begin
      st <= nst; sc <= nsc; skid <= nskid; pend <= npend;
      infl <= infl + nren - disp_cnt;
      out_valid <= nv; out_tag <= nt;
      to_dec_block <= nblk; to_dec_unblock <= nunb;
    end
  end

  p_skid_cap_r11: assert property (@(posedge clk) disable iff (!rst_n) sc <= CW'(SKID));
  p_infl_r3: assert property (@(posedge clk) disable iff (!rst_n) disp_cnt <= infl);
  p_stall_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (stall && !squash && !rob_squashing) |=> out_valid == '0);
  p_block_once_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_BLK && stall && !squash && !rob_squashing) |=> !to_dec_block);
  p_squash_unblock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (squash && (st == S_BLK || st == S_UNB || st == S_SER)) |=> (to_dec_unblock && state == S_SQ));
  p_ser_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SER && stall && !squash && !rob_squashing) |=> state == S_SER);
endmodule

// File: tb/sim_rename_stall_ctrl.sv
module sim_rename_stall_ctrl;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [1:0]  dec_valid = '0, dec_kill = '0, dec_ser_pre = '0, dec_ser_post = '0;
  logic [15:0] dec_tag = '0;
  logic exe_stall = 0, cmt_stall = 0, regs_ok = 1, squash = 0, rob_squashing = 0, rob_empty = 1;
  logic [5:0] rob_free = 20, iq_free = 20, lsq_free = 20, disp_cnt = 0;
  logic [1:0]  out_valid;
  logic [15:0] out_tag;
  logic to_dec_block, to_dec_unblock;
  logic [2:0] state;
  int n_chk = 0, n_fail = 0, man_disp = -1, last_nv = 0;

  always #5 clk = ~clk;

  rename_stall_ctrl u0 (.clk(clk), .rst_n(rst_n), .dec_valid(dec_valid), .dec_kill(dec_kill),
    .dec_ser_pre(dec_ser_pre), .dec_ser_post(dec_ser_post), .dec_tag(dec_tag),
    .exe_stall(exe_stall), .cmt_stall(cmt_stall), .regs_ok(regs_ok), .squash(squash),
    .rob_squashing(rob_squashing), .rob_empty(rob_empty), .rob_free(rob_free),
    .iq_free(iq_free), .lsq_free(lsq_free), .disp_cnt(disp_cnt), .out_valid(out_valid),
    .out_tag(out_tag), .to_dec_block(to_dec_block), .to_dec_unblock(to_dec_unblock),
    .state(state));

  task automatic chk(input string r, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", r, what, act, exp);
    end
  endtask

  task automatic obs(input string r, input int est, input int ev, input int t0, input int t1,
                     input int eb, input int eu);
    chk(r, "state", int'(state), est);
    chk(r, "valid", int'(out_valid), ev);
    if (ev[0]) chk(r, "tag lane0", int'(out_tag[7:0]), t0);
    if (ev[1]) chk(r, "tag lane1", int'(out_tag[15:8]), t1);
    chk(r, "block", int'(to_dec_block), eb);
    chk(r, "unblock", int'(to_dec_unblock), eu);
  endtask

  task automatic cyc(input logic [1:0] v, input logic [7:0] a, input logic [7:0] b,
                     input logic [1:0] k = 2'b00, input logic [1:0] p = 2'b00,
                     input logic [1:0] q = 2'b00);
    @(negedge clk);
    dec_valid = v; dec_tag = {b, a}; dec_kill = k; dec_ser_pre = p; dec_ser_post = q;
    disp_cnt = (man_disp >= 0) ? 6'(man_disp) : 6'(last_nv);
    @(posedge clk); #1;
    last_nv = $countones(out_valid);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) cyc(2'b00, 8'd0, 8'd0);
  endtask

  task automatic t_reset;
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1; #1;
    obs("R1", 0, 0, 0, 0, 0, 0);
    idle(1);
    chk("R1", "idle stays idle", int'(state), 0);
  endtask

  task automatic t_pass;
    cyc(2'b11, 8'd1, 8'd2);   obs("R2", 1, 3, 1, 2, 0, 0);
    cyc(2'b01, 8'd3, 8'd0);   obs("R2", 1, 1, 3, 0, 0, 0);
    idle(2);
  endtask

  task automatic t_room;
    iq_free = 1;
    cyc(2'b11, 8'd10, 8'd11); obs("R3", 2, 1, 10, 0, 1, 0);
    cyc(2'b00, 8'd0, 8'd0);   obs("R3", 2, 0, 0, 0, 0, 0);
    cyc(2'b00, 8'd0, 8'd0);   obs("R5", 1, 1, 11, 0, 0, 1);
    iq_free = 20; idle(2);
    rob_free = 3; iq_free = 3; lsq_free = 3; man_disp = 0;
    cyc(2'b11, 8'd20, 8'd21); obs("R3", 1, 3, 20, 21, 0, 0);
    cyc(2'b11, 8'd22, 8'd23); obs("R3", 2, 1, 22, 0, 1, 0);
    man_disp = 3;
    cyc(2'b00, 8'd0, 8'd0);   obs("R3", 2, 0, 0, 0, 0, 0);
    man_disp = -1;
    cyc(2'b00, 8'd0, 8'd0);   obs("R3", 1, 1, 23, 0, 0, 1);
    rob_free = 20; iq_free = 20; lsq_free = 20; idle(2);
  endtask

  task automatic t_stall;
    exe_stall = 1;
    cyc(2'b11, 8'd30, 8'd31); obs("R4", 2, 0, 0, 0, 1, 0);
    cyc(2'b00, 8'd0, 8'd0);   obs("R4", 2, 0, 0, 0, 0, 0);
    exe_stall = 0;
    cyc(2'b00, 8'd0, 8'd0);   obs("R5", 1, 3, 30, 31, 0, 1);
    idle(2);
    regs_ok = 0;
    cyc(2'b01, 8'd40, 8'd0);  obs("R4", 2, 0, 0, 0, 1, 0);
    regs_ok = 1;
    cyc(2'b01, 8'd41, 8'd0);  obs("R5", 1, 3, 40, 41, 0, 1);
    idle(2);
  endtask

  task automatic t_full;
    exe_stall = 1;
    cyc(2'b11, 8'd50, 8'd51); obs("R11", 2, 0, 0, 0, 1, 0);
    cyc(2'b11, 8'd52, 8'd53);
    cyc(2'b11, 8'd54, 8'd55); obs("R11", 2, 0, 0, 0, 0, 0);
    exe_stall = 0;
    cyc(2'b00, 8'd0, 8'd0);   obs("R11", 2, 3, 50, 51, 0, 0);
    cyc(2'b00, 8'd0, 8'd0);   obs("R11", 2, 3, 52, 53, 0, 0);
    cyc(2'b00, 8'd0, 8'd0);   obs("R5", 1, 3, 54, 55, 0, 1);
    idle(2);
  endtask

  task automatic t_squash;
    exe_stall = 1;
    cyc(2'b11, 8'd60, 8'd61); obs("R6", 2, 0, 0, 0, 1, 0);
    squash = 1;
    cyc(2'b11, 8'd62, 8'd63); obs("R6", 4, 0, 0, 0, 0, 1);
    squash = 0; exe_stall = 0;
    cyc(2'b00, 8'd0, 8'd0);   obs("R6", 1, 0, 0, 0, 0, 0);
    idle(1);
    rob_squashing = 1;
    cyc(2'b11, 8'd70, 8'd71); obs("R7", 4, 0, 0, 0, 0, 0);
    cyc(2'b01, 8'd72, 8'd0);  obs("R7", 4, 0, 0, 0, 0, 0);
    rob_squashing = 0;
    cyc(2'b01, 8'd73, 8'd0);  obs("R7", 1, 1, 73, 0, 0, 0);
    idle(2);
  endtask

  task automatic t_ser_before;
    rob_empty = 0;
    cyc(2'b11, 8'd80, 8'd81, 2'b00, 2'b10); obs("R8", 5, 1, 80, 0, 1, 0);
    exe_stall = 1;
    cyc(2'b00, 8'd0, 8'd0);   obs("R8", 5, 0, 0, 0, 0, 0);
    exe_stall = 0;
    cyc(2'b00, 8'd0, 8'd0);   obs("R8", 5, 0, 0, 0, 0, 0);
    rob_empty = 1;
    cyc(2'b00, 8'd0, 8'd0);   obs("R8", 1, 1, 81, 0, 0, 1);
    idle(2);
  endtask

  task automatic t_ser_after;
    rob_empty = 0;
    cyc(2'b11, 8'd90, 8'd91, 2'b00, 2'b00, 2'b01); obs("R9", 5, 1, 90, 0, 1, 0);
    rob_empty = 1;
    cyc(2'b00, 8'd0, 8'd0);   obs("R9", 5, 0, 0, 0, 0, 0);
    cyc(2'b00, 8'd0, 8'd0);   obs("R9", 1, 1, 91, 0, 0, 1);
    idle(2);
    rob_empty = 0;
    cyc(2'b01, 8'd92, 8'd0, 2'b00, 2'b00, 2'b01); obs("R9", 1, 1, 92, 0, 0, 0);
    cyc(2'b01, 8'd93, 8'd0);  obs("R9", 5, 0, 0, 0, 1, 0);
    rob_empty = 1;
    cyc(2'b00, 8'd0, 8'd0);   obs("R9", 1, 1, 93, 0, 0, 1);
    idle(2);
    cyc(2'b01, 8'd94, 8'd0, 2'b00, 2'b00, 2'b01); obs("R9", 1, 1, 94, 0, 0, 0);
    cyc(2'b00, 8'd0, 8'd0);
    cyc(2'b01, 8'd95, 8'd0);  obs("R9", 1, 1, 95, 0, 0, 0);
    idle(2);
  endtask

  task automatic t_killed;
    iq_free = 1;
    cyc(2'b11, 8'd100, 8'd101, 2'b01); obs("R10", 1, 1, 101, 0, 0, 0);
    iq_free = 20; idle(2);
  endtask

  initial begin
    #2000000;
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    t_reset;
    t_pass;
    t_room;
    t_stall;
    t_full;
    t_squash;
    t_ser_before;
    t_ser_after;
    t_killed;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule